// File: doc/BRIEF.md
# Block Address Translation Lookup

This block keeps a small register file of block translation entries and answers address lookups against it in the same cycle. Each entry maps one naturally aligned virtual block, whose size is a power of two between 128 KiB and 256 MiB, onto a physical block of the same size. Software loads an entry through a single write port as a pair of 32-bit words. The upper word carries the virtual base, an encoded block-length field and two valid bits, one for supervisor accesses and one for user accesses. The lower word carries the physical base and stored attribute bits. Every write fills a data-side copy of the entry and an instruction-side copy. The instruction-side copy is cleared when the entry is not executable or is marked guarded.

Three combinational lookups run on the registered entries. A forward port turns a virtual address into a physical one, using either the data-side or the instruction-side copies. A reverse port turns a physical address back into a virtual one. A free-slot finder reports the lowest entry that neither valid bit marks in use. A configuration input hides the upper half of the file when those entries are not enabled.

Top module: `bat_xlate`

## Requirements
- R1: After reset every entry word is zero. With no write since reset, both lookups miss with zero outputs, and the free finder reports index 0 with `free_none` low.
- R2: A write with `wr_en` high changes the entry at the next rising clock edge. Lookups see the new entry from the following cycle on, and never in the cycle of the write itself. With `wr_en` low the entries do not change.
- R3: The block-length field BL sits in upper word bits [12:2]. The block size is (BL+1)*128 KiB. The virtual start is upper bits [31:17] with bits [16:0] zero. The physical base is lower bits [31:17] with bits [16:0] zero. A forward hit needs start <= va <= start + size - 1, and then `fwd_pa` = phys + (va - start).
- R4: Upper bit 1 is the supervisor-valid bit and bit 0 is the user-valid bit. A lookup with `user_mode` high considers only entries with bit 0 set. A lookup with `user_mode` low considers only entries with bit 1 set.
- R5: When several entries match, the one with the lowest index supplies the result.
- R6: A reverse hit needs phys <= pa < phys + size - 1, so the last byte of a block does not hit. On a hit `rev_va` = start + (pa - phys). The reverse lookup uses the data-side copies.
- R7: When no entry matches, the hit flag is low and the translated output is zero, on both lookup ports.
- R8: An entry is free when bits [1:0] of its data-side upper word are both zero. `free_idx` gives the lowest free index. If no usable entry is free, `free_none` is high and `free_idx` is 0.
- R9: With `hi_en` low, entries 4 to 7 take no part in either lookup or in the free finder, and writes to them are ignored.
- R10: The instruction-side copy is written with the same words as the data-side copy when `wr_exec` is high and the guarded bit (lower word bit 3) is zero. Otherwise it is written as all zeros. `fwd_inst` high makes the forward lookup use the instruction-side copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hi_en | input | 1 | Enables entries 4 to 7 |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 3 | Entry index to write |
| wr_upper | input | 32 | Upper word: virtual base, block length, valid bits |
| wr_lower | input | 32 | Lower word: physical base and attributes, bit 3 guarded |
| wr_exec | input | 1 | Entry may be used for instruction fetch |
| user_mode | input | 1 | Lookups are user accesses when high, supervisor when low |
| fwd_inst | input | 1 | Forward lookup uses the instruction-side copies |
| fwd_va | input | 32 | Virtual address to translate |
| fwd_pa | output | 32 | Translated physical address, zero on a miss |
| fwd_hit | output | 1 | Forward lookup hit |
| rev_pa | input | 32 | Physical address to translate back |
| rev_va | output | 32 | Virtual address, zero on a miss |
| rev_hit | output | 1 | Reverse lookup hit |
| free_idx | output | 3 | Lowest free entry index |
| free_none | output | 1 | No usable entry is free |

## Verification
Several situations are hard to reach from the ports. The first is an address that two entries cover, where only the lower index may win. The second is a guarded executable entry, whose data-side copy translates while the instruction-side copy misses. The third is a write to an upper entry while those entries are disabled. The stimulus programs an entry that nests inside a larger lower-index entry. It then looks up the same addresses on both sides. Finally it writes entry 5 with the upper half disabled and enables the upper half afterwards, so the free finder and a forward miss show that the write was dropped. Lookups at the first and last byte of each block cover the asymmetric reverse end and the largest block size.

// File: rtl/bat_pkg.sv
package bat_pkg;
  parameter int ADDR_W    = 32;
  parameter int BLK_SHIFT = 17;
  parameter int BL_LSB    = 2;
  parameter int BL_W      = 11;
  parameter int SV_BIT    = 1;
  parameter int UV_BIT    = 0;
  parameter int GUARD_BIT = 3;
  parameter int SPAN_W    = ADDR_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] up;
    logic [ADDR_W-1:0] lo;
  } bat_word_t;

  function automatic logic [ADDR_W-1:0] virt_base(input logic [ADDR_W-1:0] up);
    return {up[ADDR_W-1:BLK_SHIFT], {BLK_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] phys_base(input logic [ADDR_W-1:0] lo);
    return {lo[ADDR_W-1:BLK_SHIFT], {BLK_SHIFT{1'b0}}};
  endfunction

  function automatic logic [SPAN_W-1:0] blk_size(input logic [BL_W-1:0] bl);
    logic [SPAN_W-1:0] cnt;
    cnt = {{(SPAN_W-BL_W){1'b0}}, bl} + SPAN_W'(1);
    return cnt << BLK_SHIFT;
  endfunction
endpackage

// File: rtl/bat_entry_file.sv
module bat_entry_file
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int LOW_ENT = 4,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_upper,
  input  logic [ADDR_W-1:0] wr_lower,
  input  logic              wr_exec,
  output bat_word_t         dat_q [NUM_ENT],
  output bat_word_t         ins_q [NUM_ENT]
);
  bat_word_t new_dat;
  bat_word_t new_ins;
  logic      ins_keep;

  always_comb begin
    ins_keep = wr_exec && !wr_lower[GUARD_BIT];
    new_dat  = '{up: wr_upper, lo: wr_lower};
    new_ins  = ins_keep ? new_dat : '0;
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic      ent_we;
    bat_word_t dat_d;
    bat_word_t ins_d;

    always_comb begin
      ent_we = wr_en && (wr_idx == IDX_W'(i)) && (hi_en || (i < LOW_ENT));
      dat_d  = dat_q[i];
      ins_d  = ins_q[i];
      if (ent_we) begin
        dat_d = new_dat;
        ins_d = new_ins;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[i] <= '0;
        ins_q[i] <= '0;
      end else if (ent_we) begin
        dat_q[i] <= dat_d;
        ins_q[i] <= ins_d;
      end
    end
  end
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int LOW_ENT = 4,
  parameter bit REVERSE = 1'b0
) (
  input  bat_word_t         ent [NUM_ENT],
  input  logic              hi_en,
  input  logic              user_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] result
);
  localparam logic [SPAN_W-1:0] END_ADJ = REVERSE ? SPAN_W'(1) : SPAN_W'(0);

  logic [NUM_ENT-1:0] ent_hit;
  logic [ADDR_W-1:0]  ent_out [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    logic [ADDR_W-1:0] base_in;
    logic [ADDR_W-1:0] base_out;
    logic [SPAN_W-1:0] lim;
    logic              usable;
    logic              vld;
    logic              unused_bits;

    always_comb begin
      if (REVERSE) begin
        base_in  = phys_base(ent[i].lo);
        base_out = virt_base(ent[i].up);
      end else begin
        base_in  = virt_base(ent[i].up);
        base_out = phys_base(ent[i].lo);
      end
      lim        = {1'b0, base_in} + blk_size(ent[i].up[BL_LSB+BL_W-1:BL_LSB]) - END_ADJ;
      usable     = hi_en || (i < LOW_ENT);
      vld        = user_mode ? ent[i].up[UV_BIT] : ent[i].up[SV_BIT];
      ent_hit[i] = usable && vld && (addr >= base_in) && ({1'b0, addr} < lim);
      ent_out[i] = base_out + (addr - base_in);
    end

    assign unused_bits = ^{ent[i].lo[BLK_SHIFT-1:0], ent[i].up[BLK_SHIFT-1:BL_LSB+BL_W]};
  end

  always_comb begin
    hit    = 1'b0;
    result = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (ent_hit[k]) begin
        hit    = 1'b1;
        result = ent_out[k];
      end
    end
  end
endmodule

// File: rtl/bat_free_find.sv
module bat_free_find #(
  parameter int NUM_ENT = 8,
  parameter int LOW_ENT = 4,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic [1:0]       vbits [NUM_ENT],
  input  logic             hi_en,
  output logic [IDX_W-1:0] free_idx,
  output logic             free_none
);
  logic [NUM_ENT-1:0] is_free;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_free
    assign is_free[i] = (vbits[i] == 2'b00) && (hi_en || (i < LOW_ENT));
  end

  always_comb begin
    free_none = 1'b1;
    free_idx  = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (is_free[k]) begin
        free_none = 1'b0;
        free_idx  = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int LOW_ENT = 4,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_upper,
  input  logic [ADDR_W-1:0] wr_lower,
  input  logic              wr_exec,
  input  logic              user_mode,
  input  logic              fwd_inst,
  input  logic [ADDR_W-1:0] fwd_va,
  output logic [ADDR_W-1:0] fwd_pa,
  output logic              fwd_hit,
  input  logic [ADDR_W-1:0] rev_pa,
  output logic [ADDR_W-1:0] rev_va,
  output logic              rev_hit,
  output logic [IDX_W-1:0]  free_idx,
  output logic              free_none
);
  bat_word_t  dat_q   [NUM_ENT];
  bat_word_t  ins_q   [NUM_ENT];
  bat_word_t  fwd_set [NUM_ENT];
  logic [1:0] vbits   [NUM_ENT];

  bat_entry_file #(.NUM_ENT(NUM_ENT), .LOW_ENT(LOW_ENT)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_en    (hi_en),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_upper (wr_upper),
    .wr_lower (wr_lower),
    .wr_exec  (wr_exec),
    .dat_q    (dat_q),
    .ins_q    (ins_q)
  );

  always_comb begin
    for (int k = 0; k < NUM_ENT; k++) begin
      fwd_set[k] = fwd_inst ? ins_q[k] : dat_q[k];
      vbits[k]   = {dat_q[k].up[SV_BIT], dat_q[k].up[UV_BIT]};
    end
  end

  bat_match #(.NUM_ENT(NUM_ENT), .LOW_ENT(LOW_ENT), .REVERSE(1'b0)) u_fwd (
    .ent       (fwd_set),
    .hi_en     (hi_en),
    .user_mode (user_mode),
    .addr      (fwd_va),
    .hit       (fwd_hit),
    .result    (fwd_pa)
  );

  bat_match #(.NUM_ENT(NUM_ENT), .LOW_ENT(LOW_ENT), .REVERSE(1'b1)) u_rev (
    .ent       (dat_q),
    .hi_en     (hi_en),
    .user_mode (user_mode),
    .addr      (rev_pa),
    .hit       (rev_hit),
    .result    (rev_va)
  );

  bat_free_find #(.NUM_ENT(NUM_ENT), .LOW_ENT(LOW_ENT)) u_free (
    .vbits     (vbits),
    .hi_en     (hi_en),
    .free_idx  (free_idx),
    .free_none (free_none)
  );
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int LOW_ENT = 4,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hi_en,
  input logic              wr_en,
  input logic              user_mode,
  input logic              fwd_inst,
  input logic [ADDR_W-1:0] fwd_va,
  input logic [ADDR_W-1:0] fwd_pa,
  input logic              fwd_hit,
  input logic [ADDR_W-1:0] rev_va,
  input logic              rev_hit,
  input logic [IDX_W-1:0]  free_idx,
  input logic              free_none
);
  // R7: forward miss gives zero
  a_r7_fwd_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_hit |-> (fwd_pa == '0));

  // R7: reverse miss gives zero
  a_r7_rev_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_hit |-> (rev_va == '0));

  // R8: no free entry reports index zero
  a_r8_none_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    free_none |-> (free_idx == '0));

  // R9: with the upper half hidden, only low indices are reported free
  a_r9_free_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_en && !free_none) |-> (int'(free_idx) < LOW_ENT));

  // R2: without a write, the forward result holds for unchanged inputs
  a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(fwd_va) && $stable(fwd_inst) &&
     $stable(user_mode) && $stable(hi_en)) |-> ($stable(fwd_pa) && $stable(fwd_hit)));
endmodule

bind bat_xlate bat_xlate_chk #(.NUM_ENT(NUM_ENT), .LOW_ENT(LOW_ENT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hi_en     (hi_en),
  .wr_en     (wr_en),
  .user_mode (user_mode),
  .fwd_inst  (fwd_inst),
  .fwd_va    (fwd_va),
  .fwd_pa    (fwd_pa),
  .fwd_hit   (fwd_hit),
  .rev_va    (rev_va),
  .rev_hit   (rev_hit),
  .free_idx  (free_idx),
  .free_none (free_none)
);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        usr;
    logic        ins;
    logic [31:0] va;
    logic        fh;
    logic [31:0] fpa;
    logic [31:0] pa;
    logic        rh;
    logic [31:0] rva;
  } vec_t;

  // Entries: 0 C0000000/16M->0 sup exec; 1 C1000000/128K->01000000 both, no exec;
  // 2 C0800000/256K->20000000 sup guarded; 3 10000000/256M->30000000 user exec;
  // 5 E0000000/128K->50000000 sup guarded exec
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,32'hC0000000,1'b1,32'h00000000,32'h00000000,1'b1,32'hC0000000},
    '{1'b0,1'b0,32'hC0FFFFFF,1'b1,32'h00FFFFFF,32'h00FFFFFF,1'b0,32'h0},
    '{1'b0,1'b0,32'hC0800010,1'b1,32'h00800010,32'h20000010,1'b1,32'hC0800010},
    '{1'b0,1'b0,32'hC1000000,1'b1,32'h01000000,32'h0101FFFE,1'b1,32'hC101FFFE},
    '{1'b1,1'b0,32'hC1000004,1'b1,32'h01000004,32'h00000100,1'b0,32'h0},
    '{1'b1,1'b0,32'hC0000000,1'b0,32'h0,32'h30000000,1'b1,32'h10000000},
    '{1'b1,1'b0,32'h1FFFFFFF,1'b1,32'h3FFFFFFF,32'h3FFFFFFE,1'b1,32'h1FFFFFFE},
    '{1'b0,1'b0,32'h10000000,1'b0,32'h0,32'h3FFFFFFE,1'b0,32'h0},
    '{1'b0,1'b1,32'hC0000010,1'b1,32'h00000010,32'h50000004,1'b1,32'hE0000004},
    '{1'b0,1'b1,32'hC1000000,1'b0,32'h0,32'h01000000,1'b1,32'hC1000000},
    '{1'b0,1'b1,32'hE0000000,1'b0,32'h0,32'h0101FFFF,1'b0,32'h0},
    '{1'b0,1'b0,32'hE001FFFF,1'b1,32'h5001FFFF,32'h5001FFFF,1'b0,32'h0},
    '{1'b0,1'b0,32'hE0020000,1'b0,32'h0,32'h1FFFFFFF,1'b0,32'h0},
    '{1'b1,1'b1,32'h10000000,1'b1,32'h30000000,32'h2003FFFE,1'b0,32'h0},
    '{1'b0,1'b0,32'hC0840000,1'b1,32'h00840000,32'h2003FFFE,1'b1,32'hC083FFFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_upper = '0;
  logic [31:0] wr_lower = '0;
  logic        wr_exec = 1'b0;
  logic        user_mode = 1'b0;
  logic        fwd_inst = 1'b0;
  logic [31:0] fwd_va = '0;
  logic [31:0] fwd_pa;
  logic        fwd_hit;
  logic [31:0] rev_pa = '0;
  logic [31:0] rev_va;
  logic        rev_hit;
  logic [2:0]  free_idx;
  logic        free_none;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bat_xlate uut (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_upper(wr_upper), .wr_lower(wr_lower), .wr_exec(wr_exec),
    .user_mode(user_mode), .fwd_inst(fwd_inst), .fwd_va(fwd_va),
    .fwd_pa(fwd_pa), .fwd_hit(fwd_hit), .rev_pa(rev_pa), .rev_va(rev_va),
    .rev_hit(rev_hit), .free_idx(free_idx), .free_none(free_none)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_ent(input logic [2:0] idx, input logic [31:0] up,
                           input logic [31:0] lo, input logic ex);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_upper = up; wr_lower = lo; wr_exec = ex;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic look(input logic usr, input logic ins, input logic [31:0] va,
                      input logic [31:0] pa);
    user_mode = usr; fwd_inst = ins; fwd_va = va; rev_pa = pa;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    look(1'b0, 1'b0, 32'h0, 32'h0);
    chk("R1 free_idx", 32'(free_idx), 32'd0);
    chk("R1 free_none", 32'(free_none), 32'd0);
    chk("R1 fwd_hit", 32'(fwd_hit), 32'd0);
    chk("R1 rev_hit", 32'(rev_hit), 32'd0);
    look(1'b1, 1'b0, 32'hC0000000, 32'h0);
    chk("R1 user fwd_hit", 32'(fwd_hit), 32'd0);
    chk("R7 fwd_pa zero", fwd_pa, 32'h0);

    // R2: a write becomes visible only after the clock edge
    look(1'b0, 1'b0, 32'hC0000000, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd0; wr_upper = 32'hC00001FE; wr_lower = 32'h0; wr_exec = 1'b1;
    #1;
    chk("R2 not yet visible", 32'(fwd_hit), 32'd0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R2 visible next cycle", 32'(fwd_hit), 32'd1);
    chk("R8 free after entry 0", 32'(free_idx), 32'd1);

    write_ent(3'd1, 32'hC1000003, 32'h01000000, 1'b0);
    write_ent(3'd2, 32'hC0800006, 32'h20000008, 1'b1);
    write_ent(3'd3, 32'h10001FFD, 32'h30000000, 1'b1);
    chk("R9 low half full none", 32'(free_none), 32'd1);
    chk("R8 none idx", 32'(free_idx), 32'd0);

    // R9: write to entry 5 while upper half disabled is dropped
    write_ent(3'd5, 32'hE0000002, 32'h50000008, 1'b1);
    hi_en = 1'b1;
    look(1'b0, 1'b0, 32'hE0000000, 32'h0);
    chk("R9 dropped write free_idx", 32'(free_idx), 32'd4);
    chk("R9 dropped write miss", 32'(fwd_hit), 32'd0);

    write_ent(3'd5, 32'hE0000002, 32'h50000008, 1'b1);
    chk("R8 free skips used", 32'(free_idx), 32'd4);
    chk("R8 free_none low", 32'(free_none), 32'd0);

    // R3 R4 R5 R6 R7 R10: vector table
    for (int i = 0; i < NV; i++) begin
      look(VECS[i].usr, VECS[i].ins, VECS[i].va, VECS[i].pa);
      chk($sformatf("R3/R4/R5/R10 fwd_hit v%0d", i), 32'(fwd_hit), 32'(VECS[i].fh));
      chk($sformatf("R3/R7 fwd_pa v%0d", i), fwd_pa, VECS[i].fpa);
      chk($sformatf("R6 rev_hit v%0d", i), 32'(rev_hit), 32'(VECS[i].rh));
      chk($sformatf("R6/R7 rev_va v%0d", i), rev_va, VECS[i].rva);
    end

    // R9: hiding the upper half removes entry 5 from lookups
    hi_en = 1'b0;
    look(1'b0, 1'b0, 32'hE0000000, 32'h50000004);
    chk("R9 fwd hidden", 32'(fwd_hit), 32'd0);
    chk("R9 rev hidden", 32'(rev_hit), 32'd0);
    chk("R9 free hidden", 32'(free_none), 32'd1);

    // R2: data on the port without wr_en changes nothing
    @(negedge clk);
    wr_idx = 3'd1; wr_upper = 32'h0; wr_lower = 32'h0; wr_exec = 1'b0;
    @(negedge clk);
    #1;
    chk("R2 no strobe no change", 32'(free_none), 32'd1);

    // R8: clearing both valid bits frees entry 1
    write_ent(3'd1, 32'hC1000000, 32'h01000000, 1'b0);
    look(1'b1, 1'b0, 32'hC1000000, 32'h0);
    chk("R8 freed idx", 32'(free_idx), 32'd1);
    chk("R4 cleared entry miss", 32'(fwd_hit), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule